// File: doc/BRIEF.md
# Addressing-Mode Effective Address Sequencer

This block sits between the opcode decoder and the execute stage of a small 8-bit processor with a 16-bit address space. Once the decoder has worked out an instruction's addressing mode, the block reads the operand bytes that follow the opcode. It reads them one at a time through a byte-wide read port. From those bytes and the captured registers it forms one of three results: an immediate value, a data address, or a branch target. It also reports the program counter that the next instruction fetch should use.

Seven modes are handled:
- **Implied and indirect** fetch no bytes. Indirect is built as indexed addressing with a zero offset, on the pointer register.
- **Immediate, short direct, relative and indexed** fetch one byte.
- **Extended** fetches two bytes, the high byte first.

The program counter steps by one for every byte fetched.

A relative offset is signed and is added to the program counter just past the offset byte. An indexed offset is unsigned. Both additions wrap modulo 2^16. When a relative branch is not taken, the offset byte is still consumed, but no target is applied.

The result is announced with a one-cycle `done` pulse. It stays on the outputs until the execute stage acknowledges it, and no new mode is taken before that acknowledge.

Top module: `opnd_ea_seq`

## Requirements
- R1: During and right after reset, `mode_ready` is 1, and `done` and `mem_req` are 0.
- R2: The number of operand bytes fetched depends on the mode code:
  - 0 bytes: implied (0), indirect (6) and reserved (7).
  - 1 byte: immediate (1), short direct (2), relative (4) and indexed (5).
  - 2 bytes: extended (3).

  The bytes are read from `pc_in`, `pc_in+1` and so on. Each request is held with the same address until `mem_ready` is 1.
- R3: In extended mode the first byte fetched is the high byte: `ea_out` = {first, second} and `ea_kind` = 2.
- R4: Immediate mode gives `ea_kind` = 1 and `ea_out` = {8'h00, byte}. Short direct mode gives `ea_kind` = 2 and `ea_out` = {8'h00, byte}.
- R5: A relative mode with `branch_take` = 1 gives `ea_kind` = 3. Both `ea_out` and `pc_next` equal (`pc_in`+1) plus the sign-extended byte, modulo 2^16.
- R6: A relative mode with `branch_take` = 0 gives `ea_kind` = 0, `ea_out` = 0 and `pc_next` = `pc_in`+1.
- R7: Indexed mode gives `ea_kind` = 2 and `ea_out` = `index_reg` + zero-extended byte, modulo 2^16.
- R8: Indirect mode gives `ea_kind` = 2 and `ea_out` = `pointer_reg`, with no fetch.
- R9: The following hold around the result:
  - `done` is high for exactly one cycle.
  - `ea_out`, `ea_kind` and `pc_next` stay unchanged until `exe_ack`.
  - `mode_ready` stays 0 from the accept until the cycle after `exe_ack`.
  - An `exe_ack` given in the `done` cycle itself is honoured.
- R10: For every mode other than a taken branch, `pc_next` = `pc_in` + number of bytes fetched.
- R11: Implied and reserved modes give `ea_kind` = 0 and `ea_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_valid | input | 1 | A decoded mode is offered |
| mode_code | input | 3 | Addressing-mode code |
| branch_take | input | 1 | Relative branch condition is true |
| pc_in | input | 16 | Address of the byte after the opcode |
| index_reg | input | 16 | Index register base |
| pointer_reg | input | 16 | Pointer register for indirect mode |
| mode_ready | output | 1 | Idle and able to accept a mode |
| mem_req | output | 1 | Operand byte read request |
| mem_addr | output | 16 | Read address |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| done | output | 1 | One-cycle result pulse |
| ea_out | output | 16 | Effective address, immediate value or branch target |
| ea_kind | output | 2 | 0 none, 1 value, 2 data address, 3 branch target |
| pc_next | output | 16 | Program counter for the next instruction |
| exe_ack | input | 1 | Execute stage has taken the result |

## Verification
The acknowledge of one result and the offer of the next mode can meet on adjacent edges. `exe_ack` can land in the very cycle of the `done` pulse, and the following mode is presented on the next cycle. The bench provokes this by acknowledging with zero delay and starting the next operation without an idle gap. It judges the case by requiring `mode_ready` to be back one cycle after the pulse and the next result to come out correct. A second overlap comes from fetch stalls. With `mem_ready` withdrawn on some cycles, a stalled request must keep its address while the byte counter and program counter stand still, so the result comes out as it would without stalls.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    AM_IMPL = 3'd0,
    AM_IMM  = 3'd1,
    AM_DIR  = 3'd2,
    AM_EXT  = 3'd3,
    AM_REL  = 3'd4,
    AM_IDX  = 3'd5,
    AM_IND  = 3'd6,
    AM_RSV  = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    EK_NONE   = 2'd0,
    EK_VALUE  = 2'd1,
    EK_ADDR   = 2'd2,
    EK_TARGET = 2'd3
  } ek_e;

  function automatic logic [1:0] opnd_bytes(input am_e m);
    case (m)
      AM_IMM, AM_DIR, AM_REL, AM_IDX: opnd_bytes = 2'd1;
      AM_EXT:                         opnd_bytes = 2'd2;
      default:                        opnd_bytes = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/opnd_rst_sync.sv
module opnd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/opnd_fetch_ctrl.sv
module opnd_fetch_ctrl
  import opnd_pkg::*;
#(
  parameter int AWID = AW,
  parameter int DWID = DW
) (
  input  logic            clk,
  input  logic            rst_l,
  input  logic            mode_valid,
  input  am_e             mode_in,
  input  logic            take_in,
  input  logic [AWID-1:0] pc_in,
  input  logic [AWID-1:0] idx_in,
  input  logic [AWID-1:0] ptr_in,
  output logic            mode_ready,
  output logic            mem_req,
  output logic [AWID-1:0] mem_addr,
  input  logic            mem_ready,
  input  logic [DWID-1:0] mem_rdata,
  input  logic            exe_ack,
  output logic            done,
  output am_e             mode_q,
  output logic            take_q,
  output logic [AWID-1:0] pc_q,
  output logic [AWID-1:0] base_q,
  output logic [DWID-1:0] hi_q,
  output logic [DWID-1:0] lo_q
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE, ST_HOLD} st_e;

  st_e             st_q, st_d;
  logic [1:0]      cnt_q, cnt_d;
  logic [1:0]      need;
  logic            accept, fire;
  logic            cap_en, pc_en, cnt_en, hi_en, lo_en;
  logic [AWID-1:0] pc_d;
  logic [DWID-1:0] hi_d, lo_d;

  assign need   = opnd_bytes(mode_in);
  assign accept = (st_q == ST_IDLE) && mode_valid;
  assign fire   = (st_q == ST_FETCH) && mem_ready;

  assign mode_ready = (st_q == ST_IDLE);
  assign mem_req    = (st_q == ST_FETCH);
  assign mem_addr   = pc_q;
  assign done       = (st_q == ST_DONE);

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = (need == 2'd0) ? ST_DONE : ST_FETCH;
      ST_FETCH: if (fire && cnt_q == 2'd1) st_d = ST_DONE;
      ST_DONE:  st_d = exe_ack ? ST_IDLE : ST_HOLD;
      ST_HOLD:  if (exe_ack) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // datapath next values and enables
  always_comb begin
    cap_en = accept;
    pc_en  = accept || fire;
    cnt_en = accept || fire;
    hi_en  = accept || (fire && cnt_q == 2'd2);
    lo_en  = accept || (fire && cnt_q != 2'd2);
    pc_d   = accept ? pc_in : pc_q + {{(AWID-1){1'b0}}, 1'b1};
    cnt_d  = accept ? need : cnt_q - 2'd1;
    hi_d   = accept ? '0 : mem_rdata;
    lo_d   = accept ? '0 : mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pc_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      mode_q <= AM_IMPL;
      take_q <= 1'b0;
      base_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (pc_en)  pc_q  <= pc_d;
      if (hi_en)  hi_q  <= hi_d;
      if (lo_en)  lo_q  <= lo_d;
      if (cap_en) begin
        mode_q <= mode_in;
        take_q <= take_in;
        // indirect reuses the indexed path with the pointer as base
        base_q <= (mode_in == AM_IND) ? ptr_in : idx_in;
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_l)
    done |=> !done);
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_l)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + {{(AWID-1){1'b0}}, 1'b1}));
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_l)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_l)
    (!mode_ready && !mem_req && !done) |-> ($stable(pc_q) && $stable(hi_q) && $stable(lo_q) && $stable(base_q)));
  a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_l)
    mode_ready |-> (!mem_req && !done));
endmodule

// File: rtl/opnd_ea_form.sv
module opnd_ea_form
  import opnd_pkg::*;
#(
  parameter int AWID = AW,
  parameter int DWID = DW
) (
  input  am_e             mode_q,
  input  logic            take_q,
  input  logic [AWID-1:0] pc_q,
  input  logic [AWID-1:0] base_q,
  input  logic [DWID-1:0] hi_q,
  input  logic [DWID-1:0] lo_q,
  output logic [AWID-1:0] ea,
  output ek_e             kind,
  output logic [AWID-1:0] pc_nx
);
  localparam int PADW = AWID - DWID;

  logic [AWID-1:0] lo_zx, lo_sx, hl, tgt, idx_sum, offs;

  assign lo_zx = {{PADW{1'b0}}, lo_q};
  assign lo_sx = {{PADW{lo_q[DWID-1]}}, lo_q};
  assign hl    = {{(AWID-2*DWID){1'b0}}, hi_q, lo_q};
  assign tgt   = pc_q + lo_sx;
  // indirect is indexed with a forced zero offset
  assign offs    = (mode_q == AM_IND) ? '0 : lo_zx;
  assign idx_sum = base_q + offs;

  always_comb begin
    ea    = '0;
    kind  = EK_NONE;
    pc_nx = pc_q;
    case (mode_q)
      AM_IMM:         begin ea = lo_zx;   kind = EK_VALUE; end
      AM_DIR:         begin ea = lo_zx;   kind = EK_ADDR;  end
      AM_EXT:         begin ea = hl;      kind = EK_ADDR;  end
      AM_IDX, AM_IND: begin ea = idx_sum; kind = EK_ADDR;  end
      AM_REL: if (take_q) begin
        ea    = tgt;
        kind  = EK_TARGET;
        pc_nx = tgt;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq
  import opnd_pkg::*;
#(
  parameter int AWID = AW,
  parameter int DWID = DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_valid,
  input  logic [2:0]      mode_code,
  input  logic            branch_take,
  input  logic [AWID-1:0] pc_in,
  input  logic [AWID-1:0] index_reg,
  input  logic [AWID-1:0] pointer_reg,
  output logic            mode_ready,
  output logic            mem_req,
  output logic [AWID-1:0] mem_addr,
  input  logic            mem_ready,
  input  logic [DWID-1:0] mem_rdata,
  output logic            done,
  output logic [AWID-1:0] ea_out,
  output logic [1:0]      ea_kind,
  output logic [AWID-1:0] pc_next,
  input  logic            exe_ack
);
  logic            rst_l;
  am_e             mode_q;
  logic            take_q;
  logic [AWID-1:0] pc_q, base_q;
  logic [DWID-1:0] hi_q, lo_q;
  ek_e             kind;

  opnd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_l));

  opnd_fetch_ctrl #(.AWID(AWID), .DWID(DWID)) u_ctrl (
    .clk(clk), .rst_l(rst_l),
    .mode_valid(mode_valid), .mode_in(am_e'(mode_code)), .take_in(branch_take),
    .pc_in(pc_in), .idx_in(index_reg), .ptr_in(pointer_reg),
    .mode_ready(mode_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .exe_ack(exe_ack),
    .done(done), .mode_q(mode_q), .take_q(take_q), .pc_q(pc_q),
    .base_q(base_q), .hi_q(hi_q), .lo_q(lo_q)
  );

  opnd_ea_form #(.AWID(AWID), .DWID(DWID)) u_form (
    .mode_q(mode_q), .take_q(take_q), .pc_q(pc_q), .base_q(base_q),
    .hi_q(hi_q), .lo_q(lo_q), .ea(ea_out), .kind(kind), .pc_nx(pc_next)
  );

  assign ea_kind = kind;

  a_r5_target_pc: assert property (@(posedge clk) disable iff (!rst_l)
    (done && ea_kind == 2'd3) |-> (pc_next == ea_out));
  a_r11_none_zero: assert property (@(posedge clk) disable iff (!rst_l)
    (done && ea_kind == 2'd0) |-> (ea_out == '0));
  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_l)
    (!mode_ready && !mem_req && !done) |-> ($stable(ea_out) && $stable(ea_kind) && $stable(pc_next)));
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_l |-> (mode_ready && !done && !mem_req));
endmodule

// File: tb/opnd_ea_seq_tb.sv
module opnd_ea_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_valid = 1'b0;
  logic [2:0]  mode_code = 3'd0;
  logic        branch_take = 1'b0;
  logic [15:0] pc_in = 16'h0, index_reg = 16'h0, pointer_reg = 16'h0;
  logic        mem_ready = 1'b1;
  logic        exe_ack = 1'b0;
  logic [7:0]  key = 8'h00;
  logic        mode_ready, mem_req, done;
  logic [15:0] mem_addr, ea_out, pc_next;
  logic [7:0]  mem_rdata;
  logic [1:0]  ea_kind;
  int          tests = 0, fails = 0, total_cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] fm(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ key;
  endfunction

  assign mem_rdata = fm(mem_addr);

  opnd_ea_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_valid(mode_valid), .mode_code(mode_code),
    .branch_take(branch_take), .pc_in(pc_in), .index_reg(index_reg),
    .pointer_reg(pointer_reg), .mode_ready(mode_ready), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done(done), .ea_out(ea_out), .ea_kind(ea_kind), .pc_next(pc_next),
    .exe_ack(exe_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", total_cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Called at a negedge; returns at the negedge after the acknowledge.
  task automatic run(input logic [2:0] md, input logic tk, input logic [15:0] pc,
                     input logic [15:0] idx, input logic [15:0] ptr,
                     input logic [7:0] b0want, input int ackdly, input bit stl);
    int need, nf, cyc;
    bit seen;
    logic [7:0]  b0, b1;
    logic [15:0] exp_ea, exp_pcn, tgt, ea_s, pcn_s;
    logic [1:0]  exp_k, k_s;
    string rq;

    key    = b0want ^ pc[7:0] ^ pc[15:8];
    need   = (md == 3'd3) ? 2 : (md == 3'd1 || md == 3'd2 || md == 3'd4 || md == 3'd5) ? 1 : 0;
    b0     = fm(pc);
    b1     = fm(pc + 16'd1);
    tgt    = pc + 16'd1 + {{8{b0[7]}}, b0};
    exp_pcn = pc + 16'(need);
    exp_ea = 16'h0;
    exp_k  = 2'd0;
    case (md)
      3'd1: begin exp_ea = {8'h0, b0}; exp_k = 2'd1; rq = "R4"; end
      3'd2: begin exp_ea = {8'h0, b0}; exp_k = 2'd2; rq = "R4"; end
      3'd3: begin exp_ea = {b0, b1};   exp_k = 2'd2; rq = "R3"; end
      3'd4: if (tk) begin exp_ea = tgt; exp_k = 2'd3; exp_pcn = tgt; rq = "R5"; end
            else rq = "R6";
      3'd5: begin exp_ea = idx + {8'h0, b0}; exp_k = 2'd2; rq = "R7"; end
      3'd6: begin exp_ea = ptr; exp_k = 2'd2; rq = "R8"; end
      default: rq = "R11";
    endcase

    chk(mode_ready === 1'b1, "R9 ready idle", 32'(mode_ready), 1);
    mode_valid = 1'b1; mode_code = md; branch_take = tk;
    pc_in = pc; index_reg = idx; pointer_reg = ptr;
    @(negedge clk);
    mode_valid = 1'b0; pc_in = ~pc; index_reg = ~idx; pointer_reg = ~ptr;
    branch_take = ~tk; mode_code = ~md;
    nf = 0; cyc = 0; seen = 0;
    while (!seen && cyc < 40) begin
      mem_ready = !stl || (cyc % 3 != 0);
      #1;
      if (done) seen = 1;
      else begin
        if (mem_req && mem_ready) begin
          chk(mem_addr == pc + 16'(nf), "R2 fetch addr", 32'(mem_addr), 32'(pc + 16'(nf)));
          nf++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    mem_ready = 1'b1;
    if (!seen) begin
      chk(0, "R9 no done", 0, 1);
      return;
    end
    chk(nf == need, "R2 byte count", 32'(nf), 32'(need));
    chk(ea_out == exp_ea, {rq, " ea"}, 32'(ea_out), 32'(exp_ea));
    chk(ea_kind == exp_k, {rq, " kind"}, 32'(ea_kind), 32'(exp_k));
    chk(pc_next == exp_pcn, "R10 pc_next", 32'(pc_next), 32'(exp_pcn));
    chk(mode_ready == 1'b0, "R9 busy at done", 32'(mode_ready), 0);
    ea_s = ea_out; k_s = ea_kind; pcn_s = pc_next;
    for (int i = 0; i < ackdly; i++) begin
      @(negedge clk); #1;
      chk(done == 1'b0, "R9 done pulse", 32'(done), 0);
      chk(mode_ready == 1'b0 && ea_out == ea_s && ea_kind == k_s && pc_next == pcn_s,
          "R9 hold stable", 32'(ea_out), 32'(ea_s));
    end
    exe_ack = 1'b1;
    @(negedge clk);
    exe_ack = 1'b0;
    #1;
    chk(mode_ready == 1'b1 && done == 1'b0, "R9 ready after ack", 32'(mode_ready), 1);
  endtask

  initial begin
    #1;
    chk(mode_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset", 32'({mode_ready, done, mem_req}), 32'h4);
    repeat (3) @(negedge clk);
    chk(mode_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 reset held", 32'({mode_ready, done, mem_req}), 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mode_ready == 1'b1 && done == 1'b0 && mem_req == 1'b0, "R1 after release", 32'({mode_ready, done, mem_req}), 32'h4);

    // R5: every signed offset, taken, near both ends of the space
    for (int o = 0; o < 256; o++)
      run(3'd4, 1'b1, o[0] ? 16'h0010 : 16'hFFC0, 16'h0, 16'h0, 8'(o), 0, o[2]);
    // R6: not taken
    for (int o = 0; o < 256; o += 17)
      run(3'd4, 1'b0, 16'h8000 + 16'(o), 16'h0, 16'h0, 8'(o), o % 3, 1'b0);
    // R7: every unsigned offset, base near the top so sums wrap
    for (int o = 0; o < 256; o++)
      run(3'd5, 1'b0, 16'h1234 + 16'(o), 16'hFFC0, 16'h0, 8'(o), o % 2, o[1]);
    // R3: extended, including a pc that wraps between the two bytes
    for (int i = 0; i < 16; i++)
      run(3'd3, 1'b0, (i == 0) ? 16'hFFFF : 16'(i * 16'h0F31), 16'h0, 16'h0, 8'(i * 37), i % 3, i[0]);
    // R4: immediate and short direct
    for (int i = 0; i < 16; i++) begin
      run(3'd1, 1'b0, 16'(16'h2000 + i), 16'h0, 16'h0, 8'(i * 29 + 128), 0, i[0]);
      run(3'd2, 1'b0, 16'(16'h3F00 + i), 16'h0, 16'h0, 8'(255 - i * 11), 1, 1'b0);
    end
    // R8: indirect, no fetch; index input must not matter
    for (int i = 0; i < 8; i++)
      run(3'd6, 1'b0, 16'(16'h4000 + i), 16'hAAAA, 16'(i * 16'h2345), 8'h00, i % 3, 1'b1);
    // R11: implied and reserved
    for (int i = 0; i < 4; i++) begin
      run(3'd0, 1'b1, 16'(16'h5000 + i), 16'h1111, 16'h2222, 8'h77, i, 1'b0);
      run(3'd7, 1'b1, 16'(16'h6000 + i), 16'h3333, 16'h4444, 8'h55, 0, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule